// File: doc/BRIEF.md
# Rotate-Right Unit with Shift-Opcode Decode

This combinational unit sits beside the logical right shifter of a 64-bit integer datapath. Rotates and logical right shifts share one major opcode and one set of function codes. The unit inspects the function field and one field that is otherwise zero. When that field holds the value one, it raises a rotate flag and produces the rotated value. In every other case it lowers the flag, so that the shifter keeps the instruction as a plain logical shift.

Five forms are supported:

- A 32-bit rotate by an immediate amount.
- A 64-bit rotate by an immediate amount.
- A 64-bit rotate by the immediate amount plus 32.
- A 32-bit rotate by a variable amount.
- A 64-bit rotate by a variable amount.

The variable forms take their amount from the low bits of a second register operand. The 32-bit forms rotate only the low word of the source, and their result is sign-extended to 64 bits.

Top module: `rot_unit_top`

## Requirements
- R1: The immediate forms are recognised only when `rsField` equals 5'b00001. With that value, `funcCode` 6'b000010 selects the 32-bit rotate, 6'b111010 the 64-bit rotate and 6'b111110 the 64-bit rotate by amount plus 32. Each of these raises `isRotate`.
- R2: The variable forms are recognised only when `shamtField` equals 5'b00001. With that value, `funcCode` 6'b000110 selects the 32-bit variable rotate and 6'b010110 the 64-bit variable rotate. Each of these raises `isRotate`.
- R3: When the distinguishing field of a rotate function code is not 5'b00001 (zero included), `isRotate` is 0 and `result` is all zeros.
- R4: A 32-bit rotate uses only the low 5 bits of its amount. For the variable form this is `regAmt[4:0]`; `regAmt[5]` has no effect.
- R5: A 64-bit rotate uses all 6 bits of its amount, so every amount from 0 to 63 is distinct. For the variable 64-bit form the amount is `regAmt[5:0]`.
- R6: A 32-bit rotate rotates `srcVal[31:0]` right. `result[63:32]` is a copy of `result[31]`, and `srcVal[63:32]` has no effect.
- R7: The plus-32 form rotates the full 64-bit source right by `shamtField + 32`, which covers amounts 32 to 63.
- R8: A rotate by zero returns `srcVal` unchanged for the 64-bit forms. For the 32-bit forms it returns `srcVal[31:0]` sign-extended from bit 31.
- R9: Any `funcCode` outside the five rotate codes gives `isRotate` = 0 and `result` = 0, whatever the other fields hold.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| funcCode | input | 6 | Function field of the instruction |
| rsField | input | 5 | Register-select field; selects rotate (value 1) for the immediate forms |
| shamtField | input | 5 | Shift-amount field; immediate amount, or selects rotate (value 1) for the variable forms |
| srcVal | input | 64 | Value to rotate |
| regAmt | input | 6 | Low bits of the variable-amount register operand |
| isRotate | output | 1 | High when the instruction is a rotate rather than a shift |
| result | output | 64 | Rotated value; zero when isRotate is low |

## Verification
Decoding and amount selection both read the shift-amount field in the same evaluation. For the immediate forms that field is the rotate distance. For the variable forms it is the rotate marker, while the distance comes from the register operand. The bench provokes this overlap on purpose:

- Immediate codes are applied with both `rsField` and `shamtField` equal to one.
- Variable codes are applied with `rsField` equal to one and `shamtField` zero.
- Register amounts are chosen to differ from the immediate.

A behavioural model that rotates one bit at a time judges each vector. It catches a design that takes the distance from the wrong field, or that accepts the wrong field as the rotate marker.

// File: rtl/rot_pkg.sv
package rot_pkg;
  localparam int FIELD_W = 5;
  localparam int FUNC_W  = 6;

  localparam logic [FIELD_W-1:0] MARKER_VAL = 5'b00001;

  localparam logic [FUNC_W-1:0] FN_ROT32_IMM  = 6'b000010;
  localparam logic [FUNC_W-1:0] FN_ROT64_IMM  = 6'b111010;
  localparam logic [FUNC_W-1:0] FN_ROT64_HI   = 6'b111110;
  localparam logic [FUNC_W-1:0] FN_ROT32_VAR  = 6'b000110;
  localparam logic [FUNC_W-1:0] FN_ROT64_VAR  = 6'b010110;

  typedef struct packed {
    logic rotEn;    // instruction is a rotate
    logic wideOp;   // full-width rotate instead of low half
    logic addHalf;  // add half the width to the immediate amount
    logic useReg;   // amount comes from the register operand
  } rotCtrl_t;
endpackage

// File: rtl/rot_decode.sv
module rot_decode
  import rot_pkg::*;
(
  input  logic [FUNC_W-1:0]  funcCode,
  input  logic [FIELD_W-1:0] rsField,
  input  logic [FIELD_W-1:0] shamtField,
  output rotCtrl_t           ctrl
);
  logic rsMarked;
  logic shMarked;

  assign rsMarked = (rsField == MARKER_VAL);
  assign shMarked = (shamtField == MARKER_VAL);

  always_comb begin
    ctrl = '0;
    unique case (funcCode)
      FN_ROT32_IMM: begin
        ctrl.rotEn = rsMarked;
      end
      FN_ROT64_IMM: begin
        ctrl.rotEn  = rsMarked;
        ctrl.wideOp = 1'b1;
      end
      FN_ROT64_HI: begin
        ctrl.rotEn   = rsMarked;
        ctrl.wideOp  = 1'b1;
        ctrl.addHalf = 1'b1;
      end
      FN_ROT32_VAR: begin
        ctrl.rotEn  = shMarked;
        ctrl.useReg = 1'b1;
      end
      FN_ROT64_VAR: begin
        ctrl.rotEn  = shMarked;
        ctrl.wideOp = 1'b1;
        ctrl.useReg = 1'b1;
      end
      default: ctrl = '0;
    endcase
  end
endmodule

// File: rtl/rot_barrel.sv
module rot_barrel #(
  parameter int WIDTH = 64,
  localparam int STG = $clog2(WIDTH)
) (
  input  logic [WIDTH-1:0] dIn,
  input  logic [STG-1:0]   amt,
  output logic [WIDTH-1:0] dOut
);
  logic [WIDTH-1:0] stage [0:STG];

  assign stage[0] = dIn;

  for (genvar g = 0; g < STG; g++) begin : gStage
    localparam int SH = 1 << g;
    assign stage[g+1] = amt[g] ? {stage[g][SH-1:0], stage[g][WIDTH-1:SH]}
                               : stage[g];
  end

  assign dOut = stage[STG];
endmodule

// File: rtl/rot_datapath.sv
module rot_datapath
  import rot_pkg::*;
#(
  parameter int DATA_W = 64,
  localparam int HALF_W = DATA_W / 2,
  localparam int AMT_W  = $clog2(DATA_W),
  localparam int HAMT_W = $clog2(HALF_W)
) (
  input  rotCtrl_t           ctrl,
  input  logic [FIELD_W-1:0] shamtField,
  input  logic [DATA_W-1:0]  srcVal,
  input  logic [AMT_W-1:0]   regAmt,
  output logic [DATA_W-1:0]  result
);
  logic [AMT_W-1:0]  immAmt;
  logic [AMT_W-1:0]  selAmt;
  logic [DATA_W-1:0] wideOut;
  logic [HALF_W-1:0] narrowOut;

  assign immAmt = {ctrl.addHalf, shamtField[AMT_W-2:0]};
  assign selAmt = ctrl.useReg ? regAmt : immAmt;

  rot_barrel #(.WIDTH(DATA_W)) uWide (
    .dIn (srcVal),
    .amt (selAmt),
    .dOut(wideOut)
  );

  rot_barrel #(.WIDTH(HALF_W)) uNarrow (
    .dIn (srcVal[HALF_W-1:0]),
    .amt (selAmt[HAMT_W-1:0]),
    .dOut(narrowOut)
  );

  always_comb begin
    if (!ctrl.rotEn)
      result = '0;
    else if (ctrl.wideOp)
      result = wideOut;
    else
      result = {{HALF_W{narrowOut[HALF_W-1]}}, narrowOut};
  end
endmodule

// File: rtl/rot_unit_top.sv
module rot_unit_top
  import rot_pkg::*;
(
  input  logic [5:0]  funcCode,
  input  logic [4:0]  rsField,
  input  logic [4:0]  shamtField,
  input  logic [63:0] srcVal,
  input  logic [5:0]  regAmt,
  output logic        isRotate,
  output logic [63:0] result
);
  rotCtrl_t ctrl;

  rot_decode uDecode (
    .funcCode  (funcCode),
    .rsField   (rsField),
    .shamtField(shamtField),
    .ctrl      (ctrl)
  );

  rot_datapath #(.DATA_W(64)) uPath (
    .ctrl      (ctrl),
    .shamtField(shamtField),
    .srcVal    (srcVal),
    .regAmt    (regAmt),
    .result    (result)
  );

  assign isRotate = ctrl.rotEn;
endmodule

// File: rtl/rot_unit_chk.sv
module rot_unit_chk (
  input logic [5:0]  funcCode,
  input logic [4:0]  rsField,
  input logic [4:0]  shamtField,
  input logic [63:0] srcVal,
  input logic [5:0]  regAmt,
  input logic        isRotate,
  input logic [63:0] result
);
  logic narrowCode;
  logic wideCode;

  assign narrowCode = (funcCode == 6'b000010) || (funcCode == 6'b000110);
  assign wideCode   = (funcCode == 6'b111010) || (funcCode == 6'b111110) ||
                      (funcCode == 6'b010110);

  always_comb begin
    // R3: no marker in either field means no rotate
    assert_no_marker_R3: assert (!(rsField != 5'd1 && shamtField != 5'd1) || !isRotate);

    // R3, R9: a shift leaves the result at zero
    assert_idle_zero_R9: assert (isRotate || result == 64'd0);

    // R9: only the five codes may raise the flag
    assert_code_set_R9: assert (!isRotate || narrowCode || wideCode);

    // R6: upper word mirrors bit 31 on the narrow forms
    assert_sext_R6: assert (!(isRotate && narrowCode) || result[63:32] == {32{result[31]}});

    // R5: a wide rotate preserves the count of set bits
    assert_popcnt_R5: assert (!(isRotate && wideCode) ||
                              $countones(result) == $countones(srcVal));

    // R8: a wide rotate by zero returns the source
    assert_zero_amt_R8: assert (!(isRotate && funcCode == 6'b010110 && regAmt == 6'd0) ||
                                result == srcVal);
  end
endmodule

bind rot_unit_top rot_unit_chk uChk (
  .funcCode  (funcCode),
  .rsField   (rsField),
  .shamtField(shamtField),
  .srcVal    (srcVal),
  .regAmt    (regAmt),
  .isRotate  (isRotate),
  .result    (result)
);

// File: tb/sim_rot_unit_top.sv
`timescale 1ns/1ps
module sim_rot_unit_top;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  always #5 clk = ~clk;

  logic [5:0]  funcCode;
  logic [4:0]  rsField;
  logic [4:0]  shamtField;
  logic [63:0] srcVal;
  logic [5:0]  regAmt;
  logic        isRotate;
  logic [63:0] result;

  int vecCount = 0;
  int errCount = 0;
  bit finished = 1'b0;

  rot_unit_top u0 (
    .funcCode  (funcCode),
    .rsField   (rsField),
    .shamtField(shamtField),
    .srcVal    (srcVal),
    .regAmt    (regAmt),
    .isRotate  (isRotate),
    .result    (result)
  );

  // Behavioural model: rotate one position at a time.
  function automatic void refModel(input logic [5:0] fn, input logic [4:0] rs,
                                   input logic [4:0] sh, input logic [63:0] src,
                                   input logic [5:0] ra, output logic flag,
                                   output logic [63:0] res);
    int amount;
    int width;
    logic [63:0] v;
    flag = 1'b0;
    width = 64;
    amount = 0;
    case (fn)
      6'b000010: begin flag = (rs == 5'd1); width = 32; amount = int'(sh); end
      6'b111010: begin flag = (rs == 5'd1); amount = int'(sh); end
      6'b111110: begin flag = (rs == 5'd1); amount = int'(sh) + 32; end
      6'b000110: begin flag = (sh == 5'd1); width = 32; amount = int'(ra) % 32; end
      6'b010110: begin flag = (sh == 5'd1); amount = int'(ra) % 64; end
      default: flag = 1'b0;
    endcase
    res = 64'd0;
    if (flag) begin
      v = src;
      for (int i = 0; i < amount; i++) begin
        if (width == 64) v = {v[0], v[63:1]};
        else v[31:0] = {v[0], v[31:1]};
      end
      if (width == 32) res = {{32{v[31]}}, v[31:0]};
      else res = v;
    end
  endfunction

  task automatic applyVec(input string tag, input logic [5:0] fn, input logic [4:0] rs,
                          input logic [4:0] sh, input logic [63:0] src, input logic [5:0] ra);
    logic expFlag;
    logic [63:0] expRes;
    @(posedge clk);
    #1;
    funcCode = fn; rsField = rs; shamtField = sh; srcVal = src; regAmt = ra;
    refModel(fn, rs, sh, src, ra, expFlag, expRes);
    @(negedge clk);
    vecCount++;
    if (isRotate !== expFlag || result !== expRes) begin
      errCount++;
      $display("FAIL %s fn=%b rs=%0d sh=%0d ra=%0d: actual flag=%b res=%h expected flag=%b res=%h",
               tag, fn, rs, sh, ra, isRotate, result, expFlag, expRes);
    end
  endtask

  function automatic string tagFor(input logic [5:0] fn, input logic [4:0] rs, input logic [4:0] sh);
    case (fn)
      6'b000010: return (rs == 5'd1) ? "R6" : "R3";
      6'b111010: return (rs == 5'd1) ? "R1" : "R3";
      6'b111110: return (rs == 5'd1) ? "R7" : "R3";
      6'b000110: return (sh == 5'd1) ? "R4" : "R3";
      6'b010110: return (sh == 5'd1) ? "R5" : "R3";
      default:   return "R9";
    endcase
  endfunction

  initial begin
    #1000000;
    if (!finished) begin
      errCount++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("== %0d vectors applied, %0d miscompares ==", vecCount, errCount);
      $finish;
    end
  end

  localparam logic [63:0] PAT_A = 64'h8000_0001_F00D_8001;
  localparam logic [63:0] PAT_B = 64'h1234_5678_9ABC_DEF1;

  initial begin
    funcCode = '0; rsField = '0; shamtField = '0; srcVal = '0; regAmt = '0;
    repeat (3) @(posedge clk);
    rstN = 1'b1;
    // Reset / idle state: all-zero inputs decode as a shift (R9).
    @(negedge clk);
    vecCount++;
    if (isRotate !== 1'b0 || result !== 64'd0) begin
      errCount++;
      $display("FAIL R9 idle: actual flag=%b res=%h expected flag=0 res=0", isRotate, result);
    end
    // R1: immediate forms, with the shamt field also holding one (overlap case)
    applyVec("R1", 6'b000010, 5'd1, 5'd1, PAT_A, 6'd7);
    applyVec("R1", 6'b111010, 5'd1, 5'd1, PAT_B, 6'd40);
    applyVec("R1", 6'b111110, 5'd1, 5'd1, PAT_B, 6'd3);
    // R2: variable forms, with the rs field also holding one
    applyVec("R2", 6'b000110, 5'd1, 5'd1, PAT_A, 6'd13);
    applyVec("R2", 6'b010110, 5'd1, 5'd1, PAT_B, 6'd45);
    applyVec("R2", 6'b010110, 5'd1, 5'd0, PAT_B, 6'd45);
    // R3: distinguishing field zero or other values
    applyVec("R3", 6'b000010, 5'd0, 5'd9, PAT_A, 6'd0);
    applyVec("R3", 6'b111010, 5'd2, 5'd9, PAT_A, 6'd0);
    applyVec("R3", 6'b000110, 5'd1, 5'd0, PAT_A, 6'd5);
    applyVec("R3", 6'b010110, 5'd0, 5'd3, PAT_A, 6'd5);
    // R4: bit 5 of the register amount ignored on 32-bit variable form
    applyVec("R4", 6'b000110, 5'd0, 5'd1, PAT_A, 6'd36);
    applyVec("R4", 6'b000110, 5'd0, 5'd1, PAT_A, 6'd4);
    applyVec("R4", 6'b000110, 5'd0, 5'd1, PAT_B, 6'd31);
    // R5: full 6-bit amounts on the 64-bit variable form
    applyVec("R5", 6'b010110, 5'd0, 5'd1, PAT_A, 6'd63);
    applyVec("R5", 6'b010110, 5'd0, 5'd1, PAT_A, 6'd32);
    // R6: upper source bits ignored, sign extension both ways
    applyVec("R6", 6'b000010, 5'd1, 5'd31, 64'hFFFF_FFFF_0000_0001, 6'd0);
    applyVec("R6", 6'b000010, 5'd1, 5'd1, 64'h0000_0000_0000_0001, 6'd0);
    applyVec("R6", 6'b000010, 5'd1, 5'd0, 64'hABCD_0000_7FFF_FFFF, 6'd0);
    // R7: plus-32 form extremes
    applyVec("R7", 6'b111110, 5'd1, 5'd0, PAT_B, 6'd0);
    applyVec("R7", 6'b111110, 5'd1, 5'd31, PAT_B, 6'd0);
    // R8: rotate by zero
    applyVec("R8", 6'b111010, 5'd1, 5'd0, PAT_B, 6'd17);
    applyVec("R8", 6'b010110, 5'd0, 5'd1, PAT_B, 6'd0);
    applyVec("R8", 6'b000110, 5'd0, 5'd1, 64'h1111_2222_8000_0000, 6'd32);
    // R9: unrelated function codes
    applyVec("R9", 6'b000011, 5'd1, 5'd1, PAT_A, 6'd1);
    applyVec("R9", 6'b111011, 5'd1, 5'd1, PAT_A, 6'd1);
    applyVec("R9", 6'b010010, 5'd1, 5'd1, PAT_A, 6'd1);
    // Mixed random patterns
    for (int n = 0; n < 3000; n++) begin
      logic [5:0] fn;
      logic [4:0] rs;
      logic [4:0] sh;
      int pick;
      pick = int'($urandom_range(0, 6));
      case (pick)
        0: fn = 6'b000010;
        1: fn = 6'b111010;
        2: fn = 6'b111110;
        3: fn = 6'b000110;
        4: fn = 6'b010110;
        default: fn = 6'($urandom);
      endcase
      rs = ($urandom_range(0, 2) != 0) ? 5'd1 : 5'($urandom);
      sh = ($urandom_range(0, 2) == 0) ? 5'd1 : 5'($urandom);
      applyVec(tagFor(fn, rs, sh), fn, rs, sh, {$urandom, $urandom}, 6'($urandom));
    end
    finished = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", vecCount, errCount);
    $finish;
  end
endmodule